// File: doc/BRIEF.md
# Sticky Interrupt Status Unit

This block gathers one-cycle event pulses from a serial-flash DMA controller into sticky status bits and turns them into a single level interrupt. There are nine event sources: empty, full and threshold events for the transmit FIFO and for the receive FIFO, plus descriptor-done, packet-complete and DMA-error. A pulse on the soft-reset event input counts as both FIFOs becoming empty.

Each status bit passes through two masks. The record mask decides whether an event is captured at all, and clearing a record bit also wipes the matching status bit. The line mask only decides whether a captured bit can drive the interrupt line, so software still sees every recorded event in the status word. Software can also clear status bits directly by writing ones to them. All three words share one bit layout and are reached through a simple select/write/read port.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status, record mask and line mask all read 0 and `irq_o` is 0.
- R2: All three words use the same layout: TX empty bit 0, TX full bit 1, TX threshold bit 2, RX empty bit 3, RX full bit 4, RX threshold bit 5, descriptor done bit 9, packet complete bit 10, DMA error bit 11. Bits 6, 7 and 8 cannot be written and always read 0.
- R3: An event pulse sets its status bit at the next clock edge only if the record mask bit is 1 at that edge. Otherwise the event is dropped.
- R4: A status bit that has been set stays set while no clear acts on it.
- R5: When a record mask bit reads 0, its status bit reads 0 one cycle later. A write that clears the record bit leaves the status bit visible for exactly one more cycle.
- R6: Writing the status word (select 0) clears every status bit whose write-data bit is 1. An enabled event on the same bit in the same cycle wins, so the bit stays set.
- R7: `irq_o` is registered. It is 1 in the cycle after one in which some status bit and the same line mask bit were both 1, and 0 otherwise.
- R8: The line mask has no effect on the status word's contents.
- R9: A pulse on `soft_rst_evt` acts as events on bits 0 and 3. It does not alter either mask.
- R10: `reg_rdata` shows the selected word at once: select 0 status, 1 record mask, 2 line mask, 3 reads 0. Writes with select 1 or 2 load the mask and take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 12 | One-cycle event pulses in the shared bit layout |
| soft_rst_evt | input | 1 | Controller soft-reset pulse, counts as both empty events |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Write target: 0 status (write ones to clear), 1 record mask, 2 line mask |
| reg_wdata | input | 12 | Write data |
| reg_rsel | input | 2 | Read select: 0 status, 1 record mask, 2 line mask, 3 zero |
| reg_rdata | output | 12 | Selected word, combinational |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The hardest case to reach is a collision on one status bit, where a clear and a fresh enabled event land in the same cycle. A close relative is the single-cycle window after a record bit is cleared, when the status bit is still visible. The bench builds both on purpose. It writes a clear to status while pulsing the same event. It clears a record bit and reads the status on each of the next two cycles. A long random phase then mixes events, soft-reset pulses and writes to all three words against the cycle model, so these collisions also come up in combination.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int EVW = 12;

  localparam int B_TX_EMPTY = 0;
  localparam int B_TX_FULL  = 1;
  localparam int B_TX_THR   = 2;
  localparam int B_RX_EMPTY = 3;
  localparam int B_RX_FULL  = 4;
  localparam int B_RX_THR   = 5;
  localparam int B_BD_DONE  = 9;
  localparam int B_PKT_DONE = 10;
  localparam int B_DMA_ERR  = 11;

  typedef enum logic [1:0] {
    SEL_STS  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_SIG  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Bits that exist in all three words.
  function automatic logic [EVW-1:0] valid_bits();
    logic [EVW-1:0] m;
    m = '0;
    m[B_TX_EMPTY] = 1'b1;
    m[B_TX_FULL]  = 1'b1;
    m[B_TX_THR]   = 1'b1;
    m[B_RX_EMPTY] = 1'b1;
    m[B_RX_FULL]  = 1'b1;
    m[B_RX_THR]   = 1'b1;
    m[B_BD_DONE]  = 1'b1;
    m[B_PKT_DONE] = 1'b1;
    m[B_DMA_ERR]  = 1'b1;
    return m;
  endfunction

  // Soft reset empties both FIFOs.
  function automatic logic [EVW-1:0] srst_bits();
    logic [EVW-1:0] m;
    m = '0;
    m[B_TX_EMPTY] = 1'b1;
    m[B_RX_EMPTY] = 1'b1;
    return m;
  endfunction

  // Next status: enabled events win over clears, a disabled bit drops out.
  function automatic logic [EVW-1:0] next_status(
    input logic [EVW-1:0] sts,
    input logic [EVW-1:0] en,
    input logic [EVW-1:0] ev,
    input logic [EVW-1:0] clr
  );
    return en & (ev | (sts & ~clr));
  endfunction
endpackage

// File: rtl/isu_mask_regs.sv
module isu_mask_regs
  import irq_stat_pkg::*;
#(
  parameter int W = EVW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [1:0]   wsel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_o,
  output logic [W-1:0] sig_o
);
  localparam logic [W-1:0] VMASK = valid_bits();
  localparam int NREG = 2;

  logic [W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_mask
    localparam logic [1:0] MY_SEL = (g == 0) ? SEL_EN : SEL_SIG;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      regs_q[g] <= '0;
      else if (wr && wsel == MY_SEL)   regs_q[g] <= wdata & VMASK;
    end
  end

  assign en_o  = regs_q[0];
  assign sig_o = regs_q[1];
endmodule

// File: rtl/isu_capture.sv
module isu_capture
  import irq_stat_pkg::*;
#(
  parameter int W = EVW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= next_status(sts_q, en, ev, clr);
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/isu_irq_gate.sv
module isu_irq_gate
  import irq_stat_pkg::*;
#(
  parameter int W = EVW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sts,
  input  logic [W-1:0] sig,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(sts & sig);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int W = EVW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_pulse,
  input  logic         soft_rst_evt,
  input  logic         reg_wr,
  input  logic [1:0]   reg_wsel,
  input  logic [W-1:0] reg_wdata,
  input  logic [1:0]   reg_rsel,
  output logic [W-1:0] reg_rdata,
  output logic         irq_o
);
  localparam logic [W-1:0] VMASK = valid_bits();
  localparam logic [W-1:0] SMASK = srst_bits();

  logic [W-1:0] ev_eff;
  logic [W-1:0] sts_clr;
  logic [W-1:0] en_w;
  logic [W-1:0] sig_w;
  logic [W-1:0] sts_w;

  assign ev_eff  = (evt_pulse | (soft_rst_evt ? SMASK : '0)) & VMASK;
  assign sts_clr = (reg_wr && reg_wsel == SEL_STS) ? (reg_wdata & VMASK) : '0;

  isu_mask_regs #(.W(W)) u_masks (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wsel(reg_wsel),
    .wdata(reg_wdata), .en_o(en_w), .sig_o(sig_w)
  );

  isu_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ev(ev_eff), .en(en_w),
    .clr(sts_clr), .sts_o(sts_w)
  );

  isu_irq_gate #(.W(W)) u_gate (
    .clk(clk), .rst_n(rst_n), .sts(sts_w), .sig(sig_w), .irq_o(irq_o)
  );

  always_comb begin
    unique case (reg_rsel)
      SEL_STS: reg_rdata = sts_w;
      SEL_EN:  reg_rdata = en_w;
      SEL_SIG: reg_rdata = sig_w;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irq_stat_pkg::*;
#(
  parameter int W = EVW
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] ev_eff,
  input logic [W-1:0] sts_clr,
  input logic [W-1:0] en_w,
  input logic [W-1:0] sig_w,
  input logic [W-1:0] sts_w,
  input logic         irq_o
);
  localparam logic [W-1:0] VMASK = valid_bits();

  AST_HOLES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_w | en_w | sig_w) & ~VMASK) == '0); // R2

  AST_EVENT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_eff & en_w)) |=> ((sts_w & $past(ev_eff & en_w)) == $past(ev_eff & en_w))); // R6

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr == '0) |=> ((sts_w & $past(sts_w & en_w)) == $past(sts_w & en_w))); // R4

  AST_MASKED_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_w & ~$past(en_w)) == '0)); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(sts_w & sig_w)))); // R7
endmodule

bind irq_status_unit irq_status_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_eff(ev_eff), .sts_clr(sts_clr),
  .en_w(en_w), .sig_w(sig_w), .sts_w(sts_w), .irq_o(irq_o)
);

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt_pulse = '0;
  logic        soft_rst_evt = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_wsel = '0;
  logic [11:0] reg_wdata = '0;
  logic [1:0]  reg_rsel = '0;
  logic [11:0] reg_rdata;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference state
  int m_sts = 0, m_en = 0, m_sig = 0;
  bit m_irq = 0;
  localparam int HOLES_OFF = 'h1C0;
  localparam int LEGAL     = 'hFFF & ~HOLES_OFF;

  always #10 clk = ~clk; // 50 MHz

  irq_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .soft_rst_evt(soft_rst_evt),
    .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
    .reg_rsel(reg_rsel), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on each rising edge, compared mid-high.
  always @(posedge clk) begin
    int evs, wipe, nxt;
    bit irq_n;
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_sig = 0; m_irq = 0;
    end else begin
      evs = int'(evt_pulse);
      if (soft_rst_evt) evs = evs | 9;
      evs = evs & LEGAL;
      wipe = (reg_wr && reg_wsel == 0) ? int'(reg_wdata) : 0;
      nxt = 0;
      for (int b = 0; b < 12; b++)
        if (((m_en >> b) & 1) != 0)
          if (((evs >> b) & 1) != 0 || (((m_sts >> b) & 1) != 0 && ((wipe >> b) & 1) == 0))
            nxt += (1 << b);
      irq_n = (m_sts & m_sig) != 0;
      if (reg_wr && reg_wsel == 1) m_en  = int'(reg_wdata) & LEGAL;
      if (reg_wr && reg_wsel == 2) m_sig = int'(reg_wdata) & LEGAL;
      m_sts = nxt;
      m_irq = irq_n;
    end
    #5;
    if (rst_n && !done) begin
      check("R7 irq", int'(irq_o), int'(m_irq));
      case (reg_rsel)
        2'd0: check("R10 rd status", int'(reg_rdata), m_sts);
        2'd1: check("R10 rd enable", int'(reg_rdata), m_en);
        2'd2: check("R10 rd line",   int'(reg_rdata), m_sig);
        default: check("R10 rd none", int'(reg_rdata), 0);
      endcase
    end
  end

  // Drive one cycle then return inputs to idle.
  task automatic cyc(input logic [11:0] ev, input bit sr, input bit we,
                     input logic [1:0] ws, input logic [11:0] wd);
    evt_pulse = ev; soft_rst_evt = sr; reg_wr = we; reg_wsel = ws; reg_wdata = wd;
    @(negedge clk);
    evt_pulse = '0; soft_rst_evt = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output int v);
    reg_rsel = s; #1; v = int'(reg_rdata);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, v); check("R1 status", v, 0);
    rd(1, v); check("R1 enable", v, 0);
    rd(2, v); check("R1 line", v, 0);
    check("R1 irq", int'(irq_o), 0);

    cyc(12'h200, 0, 0, 0, 0);                 // event while record mask is 0
    rd(0, v); check("R3 dropped", v, 0);

    cyc(0, 0, 1, 1, 12'hFFF);
    rd(1, v); check("R2 enable holes", v, 'hE3F);
    cyc(0, 0, 1, 2, 12'hFFF);
    rd(2, v); check("R2 line holes", v, 'hE3F);
    cyc(0, 0, 1, 2, 12'h000);

    cyc(12'hFFF, 0, 0, 0, 0);
    rd(0, v); check("R3 captured", v, 'hE3F);
    repeat (3) cyc(0, 0, 0, 0, 0);
    rd(0, v); check("R4 sticky", v, 'hE3F);
    check("R8 irq gated off", int'(irq_o), 0);
    rd(0, v); check("R8 status intact", v, 'hE3F);

    cyc(0, 0, 1, 2, 12'h800);
    check("R7 irq delay", int'(irq_o), 0);
    cyc(0, 0, 0, 0, 0);
    check("R7 irq high", int'(irq_o), 1);

    cyc(12'h001, 0, 1, 0, 12'h001);           // clear + event same bit
    rd(0, v); check("R6 event wins", v & 1, 1);
    cyc(0, 0, 1, 0, 12'h002);
    rd(0, v); check("R6 w1c", v & 2, 0);

    cyc(0, 0, 1, 1, 12'h63F);                 // drop record bit 11
    rd(0, v); check("R5 still visible", (v >> 11) & 1, 1);
    cyc(0, 0, 0, 0, 0);
    rd(0, v); check("R5 wiped", (v >> 11) & 1, 0);
    cyc(0, 0, 0, 0, 0);
    check("R7 irq falls", int'(irq_o), 0);

    cyc(0, 0, 1, 0, 12'hFFF);
    rd(0, v); check("R6 all cleared", v, 0);
    cyc(0, 1, 0, 0, 0);
    rd(0, v); check("R9 soft reset events", v, 'h009);
    rd(1, v); check("R9 enable untouched", v, 'h63F);
    rd(3, v); check("R10 select 3", v, 0);

    for (int i = 0; i < 400; i++) begin
      reg_rsel = 2'($urandom_range(0, 3));
      cyc(($urandom_range(0, 3) == 0) ? 12'($urandom) : 12'h000,
          $urandom_range(0, 15) == 0, $urandom_range(0, 5) == 0,
          2'($urandom_range(0, 2)), 12'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule